// File: doc/BRIEF.md
# Two-Edge Block Transfer Handshake Engine

This block runs the fully interlocked handshake of a multiplexed 32-bit address/data bus. One master sequencer places an address on the shared lines, raises the address strobe and waits for every slave to confirm capture. It then moves a block of words, one word on each edge of the data strobe, rising and falling alike. At the end it drops the address strobe and waits for all slaves to let go. Several slave responders sit on the same lines. Each compares the broadcast address with its own window and either takes the data or stays out of the data handshake. The four acknowledge lines are wired-OR merges of the slaves' local drives.

A user starts a transfer by pulsing `go` with an address and a word count. The master pulls each outgoing word from `src_word`, raising `src_pop` in the cycle it takes one, and pulses `done` when the transfer is over. Every slave reports each received word on its own `rx_valid` bit, with the word on its slice of `rx_word`. The whole exchange is modelled synchronously: each agent registers its drive, so a line change is seen by the other side one clock later.

Master states: MS_IDLE (waiting for `go`), MS_ADDR (address on the bus, strobe low for one setup cycle), MS_AWAIT (address strobe high, waiting for the address-release line), MS_DRISE (data strobe high, waiting for the data-release line), MS_DFALL (data strobe low, waiting for the data-acknowledge line), MS_END (both strobes low, waiting for the address-acknowledge line). Master transitions:
- MS_IDLE to MS_ADDR on `go`.
- MS_ADDR to MS_AWAIT always.
- MS_AWAIT to MS_DRISE, or to MS_END when no words remain, once the address-release line is low.
- MS_DRISE to MS_DFALL, or to MS_END, once the data-release line is low.
- MS_DFALL to MS_DRISE, or to MS_END, once the data-acknowledge line is low.
- MS_END to MS_IDLE once the address-acknowledge line is low.

Slave states: SS_IDLE, SS_HOLD (not addressed), SS_WRISE (addressed, expecting a rising data strobe) and SS_WFALL (addressed, expecting a falling one). Slave transitions:
- SS_IDLE to SS_WRISE or SS_HOLD on the address strobe, depending on the address match.
- SS_WRISE to SS_WFALL on a high data strobe.
- SS_WFALL to SS_WRISE on a low data strobe.
- Any state other than SS_IDLE back to SS_IDLE when the address strobe is low.

Top module: `hsk_top`

## Requirements
- R1: After reset both strobes are low, the address-acknowledge, data-acknowledge and data-release lines are low, the address-release line is high, and `busy` and `done` are low.
- R2: The master drives the address for one cycle with the address strobe low, then raises the strobe. It keeps the address on the bus until the address-release line is low.
- R3: On a high address strobe every idle slave asserts its address acknowledge and drops its address release. The address-release line (wired-OR) goes low only when all slaves have done so, and at that point the address-acknowledge line is high.
- R4: Slave i (counting from 0) is addressed when the address lies in [WIN_BASE + i*WIN_SIZE, WIN_BASE + (i+1)*WIN_SIZE). An address one past a window's last byte selects the next slave, or none after the last one.
- R5: The first word is driven together with a rising data strobe. Each addressed slave latches it on that edge, raises data acknowledge and drops data release. The master holds the strobe high until the data-release line is low.
- R6: Later words alternate between falling and rising data-strobe edges. On a falling edge the addressed slave latches the word, drops data acknowledge and raises data release. The master holds the strobe low until the data-acknowledge line is low. Words arrive in the order they were popped.
- R7: A slave that is not addressed still takes part in the address handshake but ignores the data strobe. It delivers no words and keeps data acknowledge and data release low.
- R8: With a length of zero the data strobe never moves. The master drops the address strobe right after the address-release line goes low.
- R9: At the end the master drops both strobes together, and a data-strobe fall that comes with the address-strobe fall carries no word. Slaves answer by releasing address acknowledge and reasserting address release. `done` pulses for one cycle once the address-acknowledge line is low, so the data strobe toggles len + (len mod 2) times per transfer.
- R10: `src_pop` is high for exactly one cycle per word, so a transfer of len words pops exactly len words.
- R11: The address 32'hFFFF_FFFF addresses every slave, and all of them receive the same block.
- R12: `go` is ignored while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start a transfer (taken only when idle) |
| go_addr | input | 32 | Target address of the transfer |
| go_len | input | LEN_W | Number of words in the block |
| src_word | input | 32 | Next word to send |
| src_pop | output | 1 | The master takes `src_word` at the coming edge |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| bus_ad | output | 32 | Multiplexed address/data lines |
| bus_as | output | 1 | Address strobe |
| bus_ds | output | 1 | Data strobe |
| line_ak | output | 1 | Wired-OR address acknowledge |
| line_ai | output | 1 | Wired-OR address release |
| line_dk | output | 1 | Wired-OR data acknowledge |
| line_di | output | 1 | Wired-OR data release |
| rx_valid | output | NSLV | Per-slave word-received pulse |
| rx_word | output | 32*NSLV | Per-slave received word, slave i in bits [32i+31:32i] |

## Verification
The assertions check the interlock rules on every cycle. They cover the address held while address release is up, the strobes frozen while the matching line is still driven, no address-strobe reassertion while acknowledge lingers, the release line falling only with acknowledge up, and one delivered word per strobe edge. Whether the right slaves were picked at the window edges, whether words arrive complete and in order, and how many strobe edges and pops a block takes can only be shown by the bench's transfers. That includes zero-length, odd and even lengths, misses, broadcast and a second `go` issued mid-transfer.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
    localparam int unsigned AD_W = 32;

    typedef enum logic [2:0] {
        MS_IDLE,
        MS_ADDR,
        MS_AWAIT,
        MS_DRISE,
        MS_DFALL,
        MS_END
    } mst_state_e;

    typedef enum logic [1:0] {
        SS_IDLE,
        SS_HOLD,
        SS_WRISE,
        SS_WFALL
    } slv_state_e;
endpackage

// File: rtl/hsk_wor.sv
module hsk_wor #(
    parameter int unsigned N = 3
) (
    input  logic [N-1:0] ak_v,
    input  logic [N-1:0] ai_v,
    input  logic [N-1:0] dk_v,
    input  logic [N-1:0] di_v,
    output logic         ak,
    output logic         ai,
    output logic         dk,
    output logic         di
);
    // each line is high while any agent pulls it
    logic [N:0] ak_c, ai_c, dk_c, di_c;

    assign ak_c[0] = 1'b0;
    assign ai_c[0] = 1'b0;
    assign dk_c[0] = 1'b0;
    assign di_c[0] = 1'b0;

    for (genvar k = 0; k < N; k++) begin : g_or
        assign ak_c[k+1] = ak_c[k] | ak_v[k];
        assign ai_c[k+1] = ai_c[k] | ai_v[k];
        assign dk_c[k+1] = dk_c[k] | dk_v[k];
        assign di_c[k+1] = di_c[k] | di_v[k];
    end

    assign ak = ak_c[N];
    assign ai = ai_c[N];
    assign dk = dk_c[N];
    assign di = di_c[N];
endmodule

// File: rtl/hsk_master.sv
module hsk_master
    import hsk_pkg::*;
#(
    parameter int unsigned LEN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [AD_W-1:0]  go_addr,
    input  logic [LEN_W-1:0] go_len,
    input  logic [AD_W-1:0]  src_word,
    output logic             src_pop,
    output logic             busy,
    output logic             done,
    output logic [AD_W-1:0]  ad_o,
    output logic             as_o,
    output logic             ds_o,
    input  logic             ak_i,
    input  logic             ai_i,
    input  logic             dk_i,
    input  logic             di_i
);
    mst_state_e       state_q, state_d;
    logic [LEN_W-1:0] rem_q;
    logic [AD_W-1:0]  ad_q;
    logic             as_q, ds_q, done_q;
    logic             load_word;
    logic             last;

    assign last = (rem_q == '0);

    always_comb begin
        state_d   = state_q;
        load_word = 1'b0;
        unique case (state_q)
            MS_IDLE:  if (go) state_d = MS_ADDR;
            MS_ADDR:  state_d = MS_AWAIT;
            MS_AWAIT: if (!ai_i) begin
                state_d   = last ? MS_END : MS_DRISE;
                load_word = !last;
            end
            MS_DRISE: if (!di_i) begin
                state_d   = last ? MS_END : MS_DFALL;
                load_word = !last;
            end
            MS_DFALL: if (!dk_i) begin
                state_d   = last ? MS_END : MS_DRISE;
                load_word = !last;
            end
            MS_END:   if (!ak_i) state_d = MS_IDLE;
            default:  state_d = MS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MS_IDLE;
        else        state_q <= state_d;
    end

    // output and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ad_q   <= '0;
            rem_q  <= '0;
            as_q   <= 1'b0;
            ds_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (state_q == MS_IDLE && go) begin
                ad_q  <= go_addr;
                rem_q <= go_len;
            end
            if (load_word) begin
                ad_q  <= src_word;
                rem_q <= rem_q - LEN_W'(1);
            end
            as_q   <= (state_d == MS_AWAIT) || (state_d == MS_DRISE) || (state_d == MS_DFALL);
            ds_q   <= (state_d == MS_DRISE);
            done_q <= (state_q == MS_END) && !ak_i;
        end
    end

    assign ad_o    = ad_q;
    assign as_o    = as_q;
    assign ds_o    = ds_q;
    assign done    = done_q;
    assign busy    = (state_q != MS_IDLE);
    assign src_pop = load_word;

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (as_q && ai_i) |=> $stable(ad_q))
        else $error("address moved before release");
    assert_ds_high_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (as_q && ds_q && di_i) |=> ds_q)
        else $error("data strobe dropped early");
    assert_ds_low_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (as_q && !ds_q && dk_i) |=> !ds_q)
        else $error("data strobe raised early");
    assert_as_reentry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_q && ak_i) |=> !as_q)
        else $error("address strobe reasserted under acknowledge");
endmodule

// File: rtl/hsk_slave.sv
module hsk_slave
    import hsk_pkg::*;
#(
    parameter logic [AD_W-1:0] BASE  = 32'h1000_0000,
    parameter logic [AD_W-1:0] SIZE  = 32'h0000_1000,
    parameter logic [AD_W-1:0] BCAST = 32'hFFFF_FFFF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AD_W-1:0] ad_i,
    input  logic            as_i,
    input  logic            ds_i,
    output logic            ak_o,
    output logic            ai_o,
    output logic            dk_o,
    output logic            di_o,
    output logic            rx_valid_o,
    output logic [AD_W-1:0] rx_word_o
);
    localparam logic [AD_W:0] LO = {1'b0, BASE};
    localparam logic [AD_W:0] HI = {1'b0, BASE} + {1'b0, SIZE};

    slv_state_e      state_q, state_d;
    logic [AD_W:0]   ad_x;
    logic            hit;
    logic            latch;
    logic            rx_valid_q;
    logic [AD_W-1:0] rx_word_q;

    assign ad_x = {1'b0, ad_i};
    assign hit  = (ad_i == BCAST) || ((ad_x >= LO) && (ad_x < HI));

    always_comb begin
        state_d = state_q;
        latch   = 1'b0;
        unique case (state_q)
            SS_IDLE:  if (as_i) state_d = hit ? SS_WRISE : SS_HOLD;
            SS_HOLD:  if (!as_i) state_d = SS_IDLE;
            SS_WRISE: if (!as_i) state_d = SS_IDLE;
                      else if (ds_i) begin
                          state_d = SS_WFALL;
                          latch   = 1'b1;
                      end
            SS_WFALL: if (!as_i) state_d = SS_IDLE;
                      else if (!ds_i) begin
                          state_d = SS_WRISE;
                          latch   = 1'b1;
                      end
            default:  state_d = SS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SS_IDLE;
        else        state_q <= state_d;
    end

    // line drives follow the state
    always_comb begin
        ak_o = (state_q != SS_IDLE);
        ai_o = (state_q == SS_IDLE);
        dk_o = (state_q == SS_WFALL);
        di_o = (state_q == SS_WRISE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid_q <= 1'b0;
            rx_word_q  <= '0;
        end else begin
            rx_valid_q <= latch;
            if (latch) rx_word_q <= ad_i;
        end
    end

    assign rx_valid_o = rx_valid_q;
    assign rx_word_o  = rx_word_q;

    assert_ak_under_as_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ak_o) |-> as_i)
        else $error("acknowledge without address strobe");
    assert_ak_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ak_o) |-> !as_i)
        else $error("acknowledge dropped under address strobe");
    assert_word_in_txn_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> as_i)
        else $error("word delivered outside a transfer");
endmodule

// File: rtl/hsk_top.sv
module hsk_top
    import hsk_pkg::*;
#(
    parameter int unsigned NSLV      = 3,
    parameter int unsigned LEN_W     = 32,
    parameter logic [31:0] WIN_BASE  = 32'h1000_0000,
    parameter logic [31:0] WIN_SIZE  = 32'h0000_1000,
    parameter logic [31:0] BCAST     = 32'hFFFF_FFFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [31:0]        go_addr,
    input  logic [LEN_W-1:0]   go_len,
    input  logic [31:0]        src_word,
    output logic               src_pop,
    output logic               busy,
    output logic               done,
    output logic [31:0]        bus_ad,
    output logic               bus_as,
    output logic               bus_ds,
    output logic               line_ak,
    output logic               line_ai,
    output logic               line_dk,
    output logic               line_di,
    output logic [NSLV-1:0]    rx_valid,
    output logic [32*NSLV-1:0] rx_word
);
    logic [NSLV-1:0] ak_v, ai_v, dk_v, di_v;

    hsk_master #(.LEN_W(LEN_W)) u_mst (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .go_addr  (go_addr),
        .go_len   (go_len),
        .src_word (src_word),
        .src_pop  (src_pop),
        .busy     (busy),
        .done     (done),
        .ad_o     (bus_ad),
        .as_o     (bus_as),
        .ds_o     (bus_ds),
        .ak_i     (line_ak),
        .ai_i     (line_ai),
        .dk_i     (line_dk),
        .di_i     (line_di)
    );

    for (genvar i = 0; i < NSLV; i++) begin : g_slv
        hsk_slave #(
            .BASE  (WIN_BASE + 32'(i) * WIN_SIZE),
            .SIZE  (WIN_SIZE),
            .BCAST (BCAST)
        ) u_slv (
            .clk        (clk),
            .rst_n      (rst_n),
            .ad_i       (bus_ad),
            .as_i       (bus_as),
            .ds_i       (bus_ds),
            .ak_o       (ak_v[i]),
            .ai_o       (ai_v[i]),
            .dk_o       (dk_v[i]),
            .di_o       (di_v[i]),
            .rx_valid_o (rx_valid[i]),
            .rx_word_o  (rx_word[32*i +: 32])
        );
    end

    hsk_wor #(.N(NSLV)) u_wor (
        .ak_v (ak_v),
        .ai_v (ai_v),
        .dk_v (dk_v),
        .di_v (di_v),
        .ak   (line_ak),
        .ai   (line_ai),
        .dk   (line_dk),
        .di   (line_di)
    );

    assert_release_with_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(line_ai) |-> line_ak)
        else $error("address release fell without acknowledge");
    assert_word_per_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|rx_valid) |-> ($past(bus_ds) != $past(bus_ds, 2)))
        else $error("word delivered without a strobe edge");
    assert_data_lines_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_as |=> !(line_dk && line_di))
        else $error("data lines both driven");
endmodule

// File: tb/hsk_top_test.sv
module hsk_top_test;
    localparam int unsigned NSLV  = 3;
    localparam int unsigned LEN_W = 32;
    localparam logic [31:0] BASE  = 32'h1000_0000;
    localparam logic [31:0] SIZE  = 32'h0000_1000;
    localparam logic [31:0] BCAST = 32'hFFFF_FFFF;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               go = 1'b0;
    logic [31:0]        go_addr = '0;
    logic [LEN_W-1:0]   go_len = '0;
    logic [31:0]        src_word;
    logic               src_pop, busy, done;
    logic [31:0]        bus_ad;
    logic               bus_as, bus_ds, line_ak, line_ai, line_dk, line_di;
    logic [NSLV-1:0]    rx_valid;
    logic [32*NSLV-1:0] rx_word;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int pops = 0;
    int base_idx = 0;
    int got [NSLV];
    int mism [NSLV];
    int edges = 0;
    int addr_bad = 0;
    logic ds_prev = 1'b0;
    logic [31:0] cur_addr = '0;
    logic [31:0] seedword = '0;

    always #10 clk = ~clk;

    hsk_top #(.NSLV(NSLV), .LEN_W(LEN_W), .WIN_BASE(BASE), .WIN_SIZE(SIZE), .BCAST(BCAST)) uut (
        .clk(clk), .rst_n(rst_n), .go(go), .go_addr(go_addr), .go_len(go_len),
        .src_word(src_word), .src_pop(src_pop), .busy(busy), .done(done),
        .bus_ad(bus_ad), .bus_as(bus_as), .bus_ds(bus_ds),
        .line_ak(line_ak), .line_ai(line_ai), .line_dk(line_dk), .line_di(line_di),
        .rx_valid(rx_valid), .rx_word(rx_word)
    );

    function automatic logic [31:0] word_of(int idx);
        return (32'(idx) * 32'h9E37_79B9) ^ seedword;
    endfunction

    function automatic bit exp_sel(int i, logic [31:0] a);
        logic [32:0] lo;
        logic [32:0] hi;
        lo = {1'b0, BASE} + 33'(i) * {1'b0, SIZE};
        hi = lo + {1'b0, SIZE};
        return (a == BCAST) || (({1'b0, a} >= lo) && ({1'b0, a} < hi));
    endfunction

    assign src_word = word_of(pops);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (src_pop) pops <= pops + 1;
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog actual %0d expected < 150000 cycles", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // bus monitor, away from the active edge
    always @(negedge clk) begin
        for (int i = 0; i < NSLV; i++) begin
            if (rx_valid[i]) begin
                if (rx_word[32*i +: 32] != word_of(base_idx + got[i])) mism[i] = mism[i] + 1;
                got[i] = got[i] + 1;
            end
        end
        if (bus_ds != ds_prev) edges = edges + 1;
        ds_prev = bus_ds;
        if (bus_as && line_ai && bus_ad != cur_addr) addr_bad = addr_bad + 1;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_txn(input logic [31:0] addr, input int len, input bit inject, input string tag);
        int waitc;
        int exp_edges;
        while (busy) @(negedge clk);
        @(negedge clk);
        base_idx = pops;
        for (int i = 0; i < NSLV; i++) begin
            got[i] = 0;
            mism[i] = 0;
        end
        edges = 0;
        addr_bad = 0;
        cur_addr = addr;
        go = 1'b1;
        go_addr = addr;
        go_len = LEN_W'(len);
        @(negedge clk);
        go = 1'b0;
        if (inject) begin
            repeat (4) @(negedge clk);
            go = 1'b1;
            go_addr = BCAST;
            go_len = LEN_W'(7);
            @(negedge clk);
            go = 1'b0;
        end
        waitc = 0;
        while (!done && waitc < 5000) begin
            @(negedge clk);
            waitc = waitc + 1;
        end
        chk(done == 1'b1, {tag, " R9 done pulse"}, done, 1);
        // end-of-transfer line levels, sampled in the done cycle
        chk(!line_ak && line_ai && !bus_as && !bus_ds,
            {tag, " R9 lines released"}, {line_ak, line_ai, bus_as, bus_ds}, 4'b0100);
        chk(pops - base_idx == len, {tag, " R10 pop count"}, pops - base_idx, len);
        for (int i = 0; i < NSLV; i++) begin
            chk(got[i] == (exp_sel(i, addr) ? len : 0),
                $sformatf("%s R4/R7/R11 slave%0d words", tag, i), got[i], exp_sel(i, addr) ? len : 0);
            chk(mism[i] == 0, $sformatf("%s R5/R6 slave%0d order", tag, i), mism[i], 0);
        end
        exp_edges = len + (len % 2);
        chk(edges == exp_edges, {tag, " R8/R9 strobe edges"}, edges, exp_edges);
        chk(addr_bad == 0, {tag, " R2 address hold"}, addr_bad, 0);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R9 done one cycle"}, done, 0);
        if (inject) begin
            repeat (4) @(negedge clk);
            chk(!busy && !bus_as, {tag, " R12 go ignored"}, {busy, bus_as}, 0);
        end
    endtask

    initial begin
        seedword = $urandom(32'd1234);
        for (int i = 0; i < NSLV; i++) begin
            got[i] = 0;
            mism[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R1 reset levels
        chk(!bus_as && !bus_ds && !line_ak && line_ai && !line_dk && !line_di && !busy && !done,
            "R1 reset state", {bus_as, bus_ds, line_ak, line_ai, line_dk, line_di, busy, done}, 8'b0001_0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(line_ai && !line_ak, "R1 idle after reset", {line_ai, line_ak}, 2'b10);

        do_txn(BASE, 0, 1'b0, "zero-len R8");
        do_txn(BASE + SIZE + 32'h10, 1, 1'b0, "one-word R5");
        do_txn(BASE + 2 * SIZE, 2, 1'b0, "two-word R6");
        do_txn(32'h2000_0000, 4, 1'b0, "miss R7");
        do_txn(BCAST, 5, 1'b0, "broadcast R11");
        do_txn(BASE + SIZE - 1, 3, 1'b0, "edge-last R4");
        do_txn(BASE + SIZE, 3, 1'b0, "edge-next R4");
        do_txn(BASE + 3 * SIZE, 2, 1'b0, "past-end R4");
        do_txn(BASE - 1, 2, 1'b0, "below-base R4");
        do_txn(BASE + SIZE + 32'h40, 40, 1'b0, "long R6");
        do_txn(BASE + 2 * SIZE + 32'h8, 6, 1'b1, "busy-go R12");

        for (int n = 0; n < 20; n++) begin
            int kind;
            int len;
            logic [31:0] a;
            kind = int'($urandom % 5);
            len = int'($urandom % 9);
            if (kind < 3) a = BASE + 32'(kind) * SIZE + ($urandom % SIZE);
            else if (kind == 3) a = BCAST;
            else a = 32'h4000_0000 + ($urandom % 32'h100);
            do_txn(a, len, 1'b0, $sformatf("random%0d", n));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule